// File: doc/BRIEF.md
# Serial Receive Error Status Flags

This block keeps the error status of a serial receiver and transmitter, together with the register that hands received bytes to software. Each completed receive frame arrives as a byte, a parity bit and a one-cycle strobe. The block checks the parity against the selected even or odd sense. On good parity it stores the byte and raises a data-full flag. On bad parity it still stores the byte, but it leaves data-full alone, raises a sticky parity-error flag and refuses later frames until software clears that flag.

In smart-card operation the transmitter sends a one-cycle strobe once it has sampled the line the receiving side uses to return an error. A low level at that strobe raises a second sticky flag. Software can clear either sticky flag only by a read of the status register that sees the flag at 1, followed by a status write that carries 0 in that flag's bit. Reset and standby wipe both flags.

Top module: `rx_err_status`

## Requirements
- R1: The parity-error flag sets one cycle after an accepted frame whose byte plus parity bit holds an odd count of ones while even sense is selected (`par_odd`=0), or an even count while odd sense is selected (`par_odd`=1).
- R2: On a parity error the byte is still written to `rx_data`, and `data_full` keeps its previous value.
- R3: An accepted frame with good parity writes the byte to `rx_data` and sets `data_full` in the next cycle. A CPU read of the data register (`cpu_sel`=1) clears `data_full`, unless a good frame is accepted in the same cycle.
- R4: While the parity-error flag is 1, `rx_done` is ignored and `rx_data` does not change. `rx_blocked` equals the parity-error flag, and `tx_hold` is 1 only while the parity-error flag is 1 and `sync_mode` is 1.
- R5: Frames that arrive with `rx_en`=0 are ignored. Dropping `rx_en` leaves the parity-error flag unchanged.
- R6: A sticky flag clears only when a status write with 0 in its bit follows a status read that returned the flag as 1. Any status write consumes that read qualification. A write of 0 without a qualifying read, or a write of 1, leaves the flag unchanged.
- R7: Reset clears every flag and `rx_data`. `standby`=1 clears both sticky flags and their read qualifications.
- R8: The error-signal flag sets when `tx_err_strobe`=1, `tx_err_line`=0, `sc_mode`=1 and `tx_en`=1. The strobe is ignored when `sc_mode`=0 or when the line is high. Dropping `tx_en` leaves the flag unchanged.
- R9: When a set event and a qualified clearing write fall in the same cycle, the flag stays 1.
- R10: A status read (`cpu_sel`=0) returns bit0=`data_full`, bit1=parity error and bit2=error signal, with all other bits 0. A data read (`cpu_sel`=1) returns `rx_data`. In `cpu_wdata`, bit0 controls the parity-error flag and bit1 controls the error-signal flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Standby entry; wipes the sticky flags |
| rx_byte | input | DW | Received byte |
| rx_par | input | 1 | Received parity bit |
| rx_done | input | 1 | One-cycle frame-complete strobe |
| rx_en | input | 1 | Receive enable |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| sync_mode | input | 1 | Synchronous operation selected |
| sc_mode | input | 1 | Smart-card operation selected |
| tx_en | input | 1 | Transmit enable |
| tx_err_strobe | input | 1 | One-cycle strobe marking the error-line sample point |
| tx_err_line | input | 1 | Sampled level of the returned error line |
| cpu_sel | input | 1 | Register select: 0 status, 1 data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 2 | Status write data: bit0 parity error, bit1 error signal |
| cpu_rdata | output | DW | Read data of the selected register |
| rx_data | output | DW | Receive data register |
| data_full | output | 1 | Receive-data-full flag |
| par_err | output | 1 | Sticky parity-error flag |
| sig_err | output | 1 | Sticky error-signal flag |
| rx_blocked | output | 1 | Reception refused while a parity error is pending |
| tx_hold | output | 1 | Transmission inhibited in synchronous operation |

## Verification
The risky overlap is a flag's set event landing in the same cycle as a qualified clearing write to that flag. The bench provokes it by arming the error-signal flag with a status read and then issuing the zero write together with a low error-line strobe. The flag must still read 1 afterwards, and a later read and write pair must clear it. A second overlap is a data-register read in the same cycle as a good frame, where data-full must remain set. The reference model in the bench judges both on every clock.

// File: rtl/rx_err_status_pkg.sv
package rx_err_status_pkg;

    localparam int unsigned NFLAG    = 2;
    localparam int unsigned PER_IDX  = 0;
    localparam int unsigned ERS_IDX  = 1;
    localparam int unsigned FULL_POS = 0;
    localparam int unsigned FLAG_POS = 1;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_DATA   = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic sig_err;
        logic par_err;
        logic full;
    } stat_t;

    typedef struct packed {
        logic rd_stat;
        logic wr_stat;
        logic rd_data;
    } cpu_op_t;

    function automatic cpu_op_t decode_cpu(logic sel, logic rd, logic wr);
        cpu_op_t op;
        op.rd_stat = rd && (reg_sel_e'(sel) == SEL_STATUS);
        op.wr_stat = wr && (reg_sel_e'(sel) == SEL_STATUS);
        op.rd_data = rd && (reg_sel_e'(sel) == SEL_DATA);
        return op;
    endfunction

endpackage

// File: rtl/rx_parity_eval.sv
module rx_parity_eval #(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0] byte_in,
    input  logic          par_bit,
    input  logic          odd_sel,
    output logic          bad
);
    logic ones_odd;

    always_comb begin
        ones_odd = ^{byte_in, par_bit};
        bad      = ones_odd ^ odd_sel;
    end
endmodule

// File: rtl/rx_sticky_flag.sv
module rx_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic wipe,
    input  logic set_ev,
    input  logic rd_hit,
    input  logic wr_hit,
    input  logic wbit,
    output logic flag
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (set_ev)
                flag <= 1'b1;
            else if (wr_hit && armed && !wbit)
                flag <= 1'b0;

            if (rd_hit)
                armed <= flag;
            else if (wr_hit)
                armed <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_data_hold.sv
module rx_data_hold #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic          good,
    input  logic [DW-1:0] byte_in,
    input  logic          drain,
    output logic [DW-1:0] data,
    output logic          full
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            full <= 1'b0;
        end else begin
            if (take)
                data <= byte_in;
            if (take && good)
                full <= 1'b1;
            else if (drain)
                full <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_err_status.sv
module rx_err_status
    import rx_err_status_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  standby,
    input  logic [DW-1:0]         rx_byte,
    input  logic                  rx_par,
    input  logic                  rx_done,
    input  logic                  rx_en,
    input  logic                  par_odd,
    input  logic                  sync_mode,
    input  logic                  sc_mode,
    input  logic                  tx_en,
    input  logic                  tx_err_strobe,
    input  logic                  tx_err_line,
    input  logic                  cpu_sel,
    input  logic                  cpu_rd,
    input  logic                  cpu_wr,
    input  logic [NFLAG-1:0]      cpu_wdata,
    output logic [DW-1:0]         cpu_rdata,
    output logic [DW-1:0]         rx_data,
    output logic                  data_full,
    output logic                  par_err,
    output logic                  sig_err,
    output logic                  rx_blocked,
    output logic                  tx_hold
);
    localparam int unsigned STAT_W = $bits(stat_t);
    localparam int unsigned PAD_W  = DW - STAT_W;

    cpu_op_t          op;
    logic             bad_par;
    logic             take;
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] flag_q;
    stat_t            stat;

    assign op = decode_cpu(cpu_sel, cpu_rd, cpu_wr);

    rx_parity_eval #(.DW(DW)) u_par (
        .byte_in (rx_byte),
        .par_bit (rx_par),
        .odd_sel (par_odd),
        .bad     (bad_par)
    );

    assign take = rx_done && rx_en && !flag_q[PER_IDX];

    rx_data_hold #(.DW(DW)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .good    (!bad_par),
        .byte_in (rx_byte),
        .drain   (op.rd_data),
        .data    (rx_data),
        .full    (data_full)
    );

    assign set_vec[PER_IDX] = take && bad_par;
    assign set_vec[ERS_IDX] = tx_err_strobe && sc_mode && tx_en && !tx_err_line;

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        rx_sticky_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .wipe   (standby),
            .set_ev (set_vec[i]),
            .rd_hit (op.rd_stat),
            .wr_hit (op.wr_stat),
            .wbit   (cpu_wdata[i]),
            .flag   (flag_q[i])
        );
    end

    assign par_err    = flag_q[PER_IDX];
    assign sig_err    = flag_q[ERS_IDX];
    assign rx_blocked = flag_q[PER_IDX];
    assign tx_hold    = flag_q[PER_IDX] && sync_mode;

    always_comb begin
        stat.full    = data_full;
        stat.par_err = flag_q[PER_IDX];
        stat.sig_err = flag_q[ERS_IDX];
        if (reg_sel_e'(cpu_sel) == SEL_DATA)
            cpu_rdata = rx_data;
        else
            cpu_rdata = {{PAD_W{1'b0}}, stat};
    end
endmodule

// File: rtl/rx_err_status_chk.sv
module rx_err_status_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          standby,
    input logic [DW-1:0] rx_byte,
    input logic          rx_par,
    input logic          rx_done,
    input logic          rx_en,
    input logic          par_odd,
    input logic          sc_mode,
    input logic          tx_en,
    input logic          tx_err_strobe,
    input logic          tx_err_line,
    input logic          cpu_sel,
    input logic          cpu_wr,
    input logic [DW-1:0] rx_data,
    input logic          data_full,
    input logic          par_err,
    input logic          sig_err
);
    logic mismatch;
    assign mismatch = (^{rx_byte, rx_par}) != par_odd;

    // R1: accepted frame with wrong parity raises the parity-error flag
    p_parity_set_r1: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rx_en && !par_err && mismatch && !standby) |=> par_err);

    // R2: a bad-parity frame never raises data-full
    p_no_full_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rx_en && !par_err && mismatch && !data_full) |=> !data_full);

    // R4: data register frozen while reception is blocked
    p_blocked_r4: assert property (@(posedge clk) disable iff (rst)
        (par_err && rx_done) |=> $stable(rx_data));

    // R6: the parity-error flag only falls after a status write, standby or reset
    p_clear_path_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(par_err) |-> ($past(cpu_wr && !cpu_sel) || $past(standby) || $past(rst)));

    // R8: error-line strobe is ignored outside smart-card mode
    p_ers_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_err_strobe && !sc_mode && !sig_err) |=> !sig_err);

    // R9: set event wins over any write
    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_err_strobe && sc_mode && tx_en && !tx_err_line && !standby) |=> sig_err);
endmodule

bind rx_err_status rx_err_status_chk #(.DW(DW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .standby       (standby),
    .rx_byte       (rx_byte),
    .rx_par        (rx_par),
    .rx_done       (rx_done),
    .rx_en         (rx_en),
    .par_odd       (par_odd),
    .sc_mode       (sc_mode),
    .tx_en         (tx_en),
    .tx_err_strobe (tx_err_strobe),
    .tx_err_line   (tx_err_line),
    .cpu_sel       (cpu_sel),
    .cpu_wr        (cpu_wr),
    .rx_data       (rx_data),
    .data_full     (data_full),
    .par_err       (par_err),
    .sig_err       (sig_err)
);

// File: tb/sim_rx_err_status.sv
module sim_rx_err_status;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int WATCHDOG = 5000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          standby = 1'b0;
    logic [DW-1:0] rx_byte = '0;
    logic          rx_par = 1'b0;
    logic          rx_done = 1'b0;
    logic          rx_en = 1'b1;
    logic          par_odd = 1'b0;
    logic          sync_mode = 1'b0;
    logic          sc_mode = 1'b0;
    logic          tx_en = 1'b1;
    logic          tx_err_strobe = 1'b0;
    logic          tx_err_line = 1'b1;
    logic          cpu_sel = 1'b0;
    logic          cpu_rd = 1'b0;
    logic          cpu_wr = 1'b0;
    logic [1:0]    cpu_wdata = 2'b11;
    logic [DW-1:0] cpu_rdata;
    logic [DW-1:0] rx_data;
    logic          data_full, par_err, sig_err, rx_blocked, tx_hold;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    rx_err_status #(.DW(DW)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    logic [DW-1:0] m_data = '0;
    bit m_full = 0, m_per = 0, m_ers = 0, m_arm_per = 0, m_arm_ers = 0;

    always @(posedge clk) begin
        bit rd_s, wr_s, rd_d, acc, badp, set_p, set_e;
        bit n_full, n_per, n_ers, n_ap, n_ae;
        if (rst) begin
            m_data = '0; m_full = 0; m_per = 0; m_ers = 0; m_arm_per = 0; m_arm_ers = 0;
        end else begin
            rd_s  = cpu_rd && !cpu_sel;
            wr_s  = cpu_wr && !cpu_sel;
            rd_d  = cpu_rd && cpu_sel;
            acc   = rx_done && rx_en && !m_per;
            badp  = (($countones(rx_byte) + int'(rx_par)) % 2) != int'(par_odd);
            set_p = acc && badp;
            set_e = tx_err_strobe && sc_mode && tx_en && !tx_err_line;
            n_full = m_full;
            if (acc && !badp) n_full = 1;
            else if (rd_d) n_full = 0;
            n_per = m_per; n_ers = m_ers; n_ap = m_arm_per; n_ae = m_arm_ers;
            if (set_p) n_per = 1;
            else if (wr_s && m_arm_per && !cpu_wdata[0]) n_per = 0;
            if (set_e) n_ers = 1;
            else if (wr_s && m_arm_ers && !cpu_wdata[1]) n_ers = 0;
            if (rd_s) begin n_ap = m_per; n_ae = m_ers; end
            else if (wr_s) begin n_ap = 0; n_ae = 0; end
            if (standby) begin n_per = 0; n_ers = 0; n_ap = 0; n_ae = 0; end
            if (acc) m_data = rx_byte;
            m_full = n_full; m_per = n_per; m_ers = n_ers;
            m_arm_per = n_ap; m_arm_ers = n_ae;
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at t=%0t", req, got, exp, $time);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2/R3 rx_data", int'(rx_data), int'(m_data));
            chk("R3 data_full", int'(data_full), int'(m_full));
            chk("R1 par_err", int'(par_err), int'(m_per));
            chk("R8 sig_err", int'(sig_err), int'(m_ers));
            chk("R4 rx_blocked", int'(rx_blocked), int'(m_per));
            chk("R4 tx_hold", int'(tx_hold), int'(m_per && sync_mode));
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic frame(input logic [DW-1:0] b, input logic p);
        @(negedge clk); rx_byte = b; rx_par = p; rx_done = 1'b1;
        @(negedge clk); rx_done = 1'b0;
    endtask

    task automatic rd_reg(input logic sel, output logic [DW-1:0] v);
        @(negedge clk); cpu_sel = sel; cpu_rd = 1'b1;
        #1 v = cpu_rdata;
        @(negedge clk); cpu_rd = 1'b0; cpu_sel = 1'b0;
    endtask

    task automatic wr_stat(input logic [1:0] w);
        @(negedge clk); cpu_sel = 1'b0; cpu_wr = 1'b1; cpu_wdata = w;
        @(negedge clk); cpu_wr = 1'b0; cpu_wdata = 2'b11;
    endtask

    task automatic err_strobe(input logic line);
        @(negedge clk); tx_err_strobe = 1'b1; tx_err_line = line;
        @(negedge clk); tx_err_strobe = 1'b0; tx_err_line = 1'b1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        logic [DW-1:0] v;
        tick(3);
        rst = 1'b0;
        tick(1);
        // R10 / R7: reset state
        rd_reg(1'b0, v); chk("R10 status after reset", int'(v), 0);
        rd_reg(1'b1, v); chk("R7 data after reset", int'(v), 0);

        // R3: good frame, even sense (A5 has four ones, parity 0)
        frame(8'hA5, 1'b0);
        chk("R3 full after good frame", int'(data_full), 1);
        rd_reg(1'b0, v); chk("R10 status full only", int'(v), 1);
        rd_reg(1'b1, v); chk("R3 data read", int'(v), 'hA5);
        chk("R3 data read drains full", int'(data_full), 0);

        // R1: odd sense, one 1 total -> good
        par_odd = 1'b1;
        frame(8'h01, 1'b0);
        chk("R1 odd sense good frame", int'(par_err), 0);
        // R1 / R2: even sense, three 1s -> error; full stays 1
        par_odd = 1'b0;
        frame(8'h03, 1'b1);
        chk("R1 parity error set", int'(par_err), 1);
        chk("R2 data stored on error", int'(rx_data), 'h03);
        chk("R2 full unchanged", int'(data_full), 1);
        chk("R4 rx_blocked", int'(rx_blocked), 1);
        chk("R4 tx_hold async", int'(tx_hold), 0);
        sync_mode = 1'b1; tick(1);
        chk("R4 tx_hold sync", int'(tx_hold), 1);
        sync_mode = 1'b0;

        // R4: frame refused while blocked
        frame(8'h55, 1'b0);
        chk("R4 data frozen", int'(rx_data), 'h03);
        // R5: dropping rx_en keeps the flag
        rx_en = 1'b0; tick(2);
        chk("R5 rx_en off keeps par_err", int'(par_err), 1);

        // R6: write 0 without a qualifying read
        wr_stat(2'b10);
        chk("R6 unqualified write", int'(par_err), 1);
        // R6: read then write 1 consumes qualification
        rd_reg(1'b0, v); chk("R10 status shows error", int'(v), 'h3);
        wr_stat(2'b11);
        chk("R6 write of one", int'(par_err), 1);
        wr_stat(2'b10);
        chk("R6 qualification consumed", int'(par_err), 1);
        rd_reg(1'b0, v);
        wr_stat(2'b10);
        chk("R6 qualified clear", int'(par_err), 0);

        // R5: frame with rx_en low ignored
        frame(8'h0F, 1'b1);
        chk("R5 disabled frame data", int'(rx_data), 'h03);
        chk("R5 disabled frame flag", int'(par_err), 0);
        rx_en = 1'b1;

        // R8: error line
        sc_mode = 1'b0; err_strobe(1'b0);
        chk("R8 ignored outside smart-card", int'(sig_err), 0);
        sc_mode = 1'b1; err_strobe(1'b1);
        chk("R8 line high no error", int'(sig_err), 0);
        err_strobe(1'b0);
        chk("R8 line low sets", int'(sig_err), 1);
        tx_en = 1'b0; tick(2);
        chk("R8 tx_en off keeps flag", int'(sig_err), 1);
        tx_en = 1'b1;

        // R9: set and qualified clear in the same cycle
        rd_reg(1'b0, v);
        @(negedge clk); cpu_wr = 1'b1; cpu_wdata = 2'b01;
        tx_err_strobe = 1'b1; tx_err_line = 1'b0;
        @(negedge clk); cpu_wr = 1'b0; cpu_wdata = 2'b11;
        tx_err_strobe = 1'b0; tx_err_line = 1'b1;
        chk("R9 set wins", int'(sig_err), 1);
        rd_reg(1'b0, v);
        wr_stat(2'b01);
        chk("R6 error-signal clear", int'(sig_err), 0);

        // R3: data read in same cycle as good frame keeps full
        frame(8'h11, 1'b0);
        rd_reg(1'b1, v);
        @(negedge clk); cpu_sel = 1'b1; cpu_rd = 1'b1;
        rx_byte = 8'h33; rx_par = 1'b0; rx_done = 1'b1;
        @(negedge clk); cpu_rd = 1'b0; cpu_sel = 1'b0; rx_done = 1'b0;
        chk("R3 frame beats drain", int'(data_full), 1);

        // R7: standby wipes both flags
        frame(8'h01, 1'b0);
        err_strobe(1'b0);
        chk("R7 both flags set", int'({sig_err, par_err}), 3);
        @(negedge clk); standby = 1'b1;
        @(negedge clk); standby = 1'b0;
        chk("R7 standby clears", int'({sig_err, par_err}), 0);
        // R7: reset clears
        frame(8'h01, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R7 reset clears", int'({sig_err, par_err, data_full}), 0);
        chk("R7 reset data", int'(rx_data), 0);
        tick(2);
        finish_run();
    end
endmodule